// File: doc/BRIEF.md
# Dual-Edge XOR Clock Divider

This block divides an input clock by a programmable integer ratio and keeps a 50% duty cycle, including for odd ratios. Because the output transitions are placed at half-cycle resolution, the high time of an odd-ratio output ends on a falling edge of the input clock. The input clock never passes through logic and never reaches a data input. The output is the XOR of two toggle registers. One register is clocked on the rising edge and the other on the falling edge, so every output transition is one clock-to-Q delay followed by one XOR stage.

A rising-edge counter runs from 0 to D-1. A two-state scheduler marks where the transitions fall. In state PH_LEAD the counter is below the midpoint D/2 (rounded down). In state PH_TRAIL the counter is between the midpoint and D-1. Reset enters PH_LEAD. PH_LEAD moves to PH_TRAIL when the counter reaches midpoint-1. PH_TRAIL moves back to PH_LEAD when the counter wraps at D-1. The rising-edge register toggles when the count is 0. For an even ratio it also toggles at the midpoint. For an odd ratio, the scheduler registers a one-cycle request at the midpoint, and the falling-edge register toggles on the falling edge that follows. The ratio is captured at every counter wrap, so a new value only takes effect at a period boundary.

Top module: `dualedge_clk_div`

## Requirements
- R1: While reset is sampled high, the counter returns to 0. The output is low no later than one full input cycle after reset is first sampled, and it stays low for as long as reset is held.
- R2: After reset is released, the output rises on the first rising clock edge at which reset is sampled low.
- R3: For an even ratio D, every high and every low interval of the output lasts exactly D half-cycles of the input clock.
- R4: For an odd ratio D, every high interval lasts exactly D half-cycles of the input clock, that is (D-1)/2 cycles plus one half-cycle.
- R5: Every low interval lasts D half-cycles, so the output period is exactly D input cycles. The internal count always stays below the active ratio.
- R6: A ratio input of 0 or 1 is treated as 2.
- R7: A change of the ratio input takes effect only at the next counter wrap. The output period in progress finishes with the old ratio, and the periods after it use the new ratio.
- R8: Rising output transitions always occur on rising input edges. The rising-edge register toggles only at count 0, or at count D/2 when D is even.
- R9: A falling output transition occurs on a falling input edge if and only if D is odd. The falling-edge register toggles only in response to a request registered on the preceding rising edge, and such a request occurs only for an odd ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; both of its edges are used |
| rst | input | 1 | Synchronous reset, active high |
| div_ratio | input | RATIO_W | Divide ratio D; values below 2 are treated as 2 |
| clk_out | output | 1 | Divided output, the XOR of the two toggle registers |

## Verification
The bench sets the ratio under reset and then measures every high and low interval of the output in half-cycle samples. It also records whether each transition landed on a rising or a falling input edge. Even ratios, including the minimum of 2, show whether the rising-edge register alone produces both transitions. Odd ratios, including 3 and the maximum of 255, show whether the falling edge takes over exactly the mid-period transition. Ratio inputs of 0 and 1 exercise the clamp. A ratio change made just after an output rise shows whether the current period keeps the old ratio, and a reset asserted mid-run shows that the output returns low. Random ratios from a fixed seed cover the remaining mix of odd and even values.

// File: rtl/dediv_pkg.sv
package dediv_pkg;

    // Scheduler phase within one output period
    typedef enum logic [0:0] {
        PH_LEAD  = 1'b0,   // counter below midpoint
        PH_TRAIL = 1'b1    // counter at or past midpoint
    } phase_e;

endpackage

// File: rtl/dediv_ratio_latch.sv
module dediv_ratio_latch #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [RATIO_W-1:0] half_q,
    output logic               odd_q
);

    localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(2);

    logic [RATIO_W-1:0] ratio_next;

    always_comb begin
        ratio_next = (ratio_in < MIN_RATIO) ? MIN_RATIO : ratio_in;
    end

    // Captured during reset and at each period wrap only
    always_ff @(posedge clk) begin
        if (rst || load) begin
            ratio_q <= ratio_next;
        end
    end

    always_comb begin
        half_q = ratio_q >> 1;
        odd_q  = ratio_q[0];
    end

endmodule

// File: rtl/dediv_sched.sv
module dediv_sched
    import dediv_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_q,
    input  logic [RATIO_W-1:0] half_q,
    input  logic               odd_q,
    output logic [RATIO_W-1:0] cnt,
    output logic               wrap,
    output logic               rise_tgl,
    output logic               fall_req
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    phase_e ph, ph_nxt;
    logic   at_mid;
    logic   set_fall;

    always_comb begin
        wrap   = (cnt == ratio_q - ONE);
        at_mid = (cnt == half_q);
    end

    // Next-state logic
    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_LEAD:  if (cnt == half_q - ONE) ph_nxt = PH_TRAIL;
            PH_TRAIL: if (wrap)                ph_nxt = PH_LEAD;
            default:                           ph_nxt = PH_LEAD;
        endcase
    end

    // State and counter register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_LEAD;
            cnt <= '0;
        end else begin
            ph  <= ph_nxt;
            cnt <= wrap ? '0 : cnt + ONE;
        end
    end

    // Outputs derived from state
    always_comb begin
        rise_tgl = 1'b0;
        set_fall = 1'b0;
        unique case (ph)
            PH_LEAD:  rise_tgl = (cnt == '0);
            PH_TRAIL: begin
                rise_tgl = !odd_q && at_mid;
                set_fall = odd_q && at_mid;
            end
            default: ;
        endcase
        if (rst) rise_tgl = 1'b0;
    end

    // One-cycle request seen by the falling-edge register
    always_ff @(posedge clk) begin
        if (rst) fall_req <= 1'b0;
        else     fall_req <= set_fall;
    end

endmodule

// File: rtl/dediv_edge_pair.sv
module dediv_edge_pair (
    input  logic clk,
    input  logic rst,
    input  logic rise_tgl,
    input  logic fall_req,
    output logic q_rise,
    output logic q_fall,
    output logic clk_out
);

    always_ff @(posedge clk) begin
        if (rst)           q_rise <= 1'b0;
        else if (rise_tgl) q_rise <= ~q_rise;
    end

    always_ff @(negedge clk) begin
        if (rst)           q_fall <= 1'b0;
        else if (fall_req) q_fall <= ~q_fall;
    end

    // Only register outputs reach the pin
    always_comb begin
        clk_out = q_rise ^ q_fall;
    end

endmodule

// File: rtl/dualedge_clk_div.sv
module dualedge_clk_div #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] div_ratio,
    output logic               clk_out
);

    logic [RATIO_W-1:0] ratio_w;
    logic [RATIO_W-1:0] half_w;
    logic               odd_w;
    logic [RATIO_W-1:0] cnt_w;
    logic               wrap_w;
    logic               rise_tgl_w;
    logic               fall_req_w;
    logic               q_rise_w;
    logic               q_fall_w;

    dediv_ratio_latch #(.RATIO_W(RATIO_W)) u_ratio (
        .clk      (clk),
        .rst      (rst),
        .load     (wrap_w),
        .ratio_in (div_ratio),
        .ratio_q  (ratio_w),
        .half_q   (half_w),
        .odd_q    (odd_w)
    );

    dediv_sched #(.RATIO_W(RATIO_W)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .ratio_q  (ratio_w),
        .half_q   (half_w),
        .odd_q    (odd_w),
        .cnt      (cnt_w),
        .wrap     (wrap_w),
        .rise_tgl (rise_tgl_w),
        .fall_req (fall_req_w)
    );

    dediv_edge_pair u_edges (
        .clk      (clk),
        .rst      (rst),
        .rise_tgl (rise_tgl_w),
        .fall_req (fall_req_w),
        .q_rise   (q_rise_w),
        .q_fall   (q_fall_w),
        .clk_out  (clk_out)
    );

endmodule

// File: rtl/dediv_chk.sv
module dediv_chk #(
    parameter int RATIO_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [RATIO_W-1:0] cnt,
    input logic [RATIO_W-1:0] ratio_q,
    input logic               fall_req,
    input logic               q_r,
    input logic               q_f
);

    // R5: count stays inside the active period
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt < ratio_q);

    // R6: the active ratio is never below 2
    p_ratio_floor_r6: assert property (@(posedge clk) disable iff (rst)
        ratio_q >= RATIO_W'(2));

    // R7: the ratio moves only when a new period has just begun
    p_ratio_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(ratio_q));

    // R8: rising-edge register toggles only at count 0 or the even midpoint
    p_rise_sched_r8: assert property (@(posedge clk) disable iff (rst)
        ((q_r != $past(q_r)) && !$past(rst)) |->
        (($past(cnt) == '0) ||
         (!$past(ratio_q[0]) && ($past(cnt) == ($past(ratio_q) >> 1)))));

    // R9: falling-edge register toggles only on a registered request
    p_fall_on_req_r9: assert property (@(negedge clk) disable iff (rst)
        ((q_f != $past(q_f)) && !$past(rst)) |-> $past(fall_req));

    // R9: requests are raised only for odd ratios
    p_fall_odd_r9: assert property (@(posedge clk) disable iff (rst)
        (fall_req && !$past(rst)) |-> $past(ratio_q[0]));

endmodule

bind dualedge_clk_div dediv_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_w),
    .ratio_q  (ratio_w),
    .fall_req (fall_req_w),
    .q_r      (q_rise_w),
    .q_f      (q_fall_w)
);

// File: tb/test_dualedge_clk_div.sv
module test_dualedge_clk_div;

    localparam int RATIO_W = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [RATIO_W-1:0] div_ratio = '0;
    logic               clk_out;

    int checks = 0;
    int errors = 0;
    bit at_rise = 1'b0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dualedge_clk_div #(.RATIO_W(RATIO_W)) i_dualedge_clk_div (
        .clk       (clk),
        .rst       (rst),
        .div_ratio (div_ratio),
        .clk_out   (clk_out)
    );

    function automatic int eff_ratio(int d);
        return (d < 2) ? 2 : d;
    endfunction

    function automatic bit fall_on_negedge(int d);
        return eff_ratio(d) % 2 == 1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Move to a quarter period after the next clock edge
    task automatic half_step();
        @(posedge clk or negedge clk);
        #5;
        at_rise = clk;
    endtask

    task automatic get_run(output int len, output bit ended_rise);
        bit v;
        v   = clk_out;
        len = 0;
        while (clk_out == v && len < 1100) begin
            len++;
            half_step();
        end
        ended_rise = at_rise;
    endtask

    task automatic start(int d);
        rst       = 1'b1;
        div_ratio = RATIO_W'(d);
        repeat (4) half_step();
        check(clk_out == 1'b0, "R1", "output in reset", clk_out, 0);
        do half_step(); while (!at_rise);
        rst = 1'b0;
        half_step();
        half_step();
        check(clk_out == 1'b1 && at_rise, "R2", "first rise after release", clk_out, 1);
    endtask

    task automatic run_periods(int d, int n, string tag);
        int e;
        int len;
        bit er;
        e = eff_ratio(d);
        for (int i = 0; i < n; i++) begin
            get_run(len, er);
            check(len == e, tag, "high half-cycles", len, e);
            check(er == !fall_on_negedge(d), fall_on_negedge(d) ? "R9" : "R8",
                  "fall edge is rising", er, !fall_on_negedge(d));
            get_run(len, er);
            check(len == e, "R5", "low half-cycles", len, e);
            check(er == 1'b1, "R8", "rise edge is rising", er, 1);
        end
    endtask

    initial begin
        int d;
        void'($urandom(32'd2024));

        start(2);   run_periods(2, 4, "R3");
        start(4);   run_periods(4, 3, "R3");
        start(3);   run_periods(3, 4, "R4");
        start(5);   run_periods(5, 3, "R4");
        start(255); run_periods(255, 2, "R4");
        start(0);   run_periods(0, 3, "R6");
        start(1);   run_periods(1, 3, "R6");

        // R7: change just after a rise; current period keeps the old ratio
        start(5);
        run_periods(5, 2, "R4");
        div_ratio = RATIO_W'(8);
        run_periods(5, 1, "R7");
        run_periods(8, 3, "R7");
        div_ratio = RATIO_W'(3);
        run_periods(8, 1, "R7");
        run_periods(3, 2, "R7");

        // R1: reset in the middle of a run
        start(7);
        run_periods(7, 1, "R4");
        repeat (5) half_step();
        rst = 1'b1;
        repeat (4) half_step();
        check(clk_out == 1'b0, "R1", "output after mid-run reset", clk_out, 0);
        repeat (4) half_step();
        check(clk_out == 1'b0, "R1", "output held in reset", clk_out, 0);

        for (int k = 0; k < 12; k++) begin
            d = $urandom_range(40, 2);
            start(d);
            run_periods(d, 4, (d % 2 == 1) ? "R4" : "R3");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule